// File: doc/BRIEF.md
# Descriptor-Chain DMA Queue Engine

This block walks a linked list of buffer descriptors in a local dual-ported descriptor RAM and streams the described buffers out one byte per handshake. Each descriptor is four 32-bit words. Software builds the descriptors and their buffers through a host RAM port, sets the enable bit, and writes the byte address of the first descriptor into the head register. The engine then fetches that descriptor, streams the buffer, writes a status word back, and follows the next pointer.

Ownership passes between software and engine through a flag in each descriptor. The engine clears that flag when it finishes a descriptor. When the next pointer is zero, it sets an end-of-queue flag and goes idle with the head register reading zero. When software appends to a list the engine has already drained, it sees that flag and restarts the channel by writing the head register again. A completion register holds the address of the descriptor software has last reclaimed. A self-clearing soft-reset bit returns the registers to their idle values.

Pointers are word-aligned byte addresses. The RAM word index is address bits [IDX_W+1:2].

Top module: `dmaq_engine`

## Requirements
- R1: After rstN is released, headPtr and complPtr read 0, chanEnable and resetBusy are 0, idle is 1 and strmValid is 0.
- R2: A register write with regSel=0 loads regWdata into headPtr only while idle is 1 and resetBusy is 0; while the engine is busy the write is ignored. Processing starts when headPtr is non-zero and the channel is enabled.
- R3: Descriptor words at offsets 0, 1, 2 and 3 hold the next pointer, the buffer pointer, the byte length (low 11 bits) and the mode word. The engine streams exactly that many bytes from the buffer. Byte k comes from word k/4, lane k%4, with lane 0 in bits [7:0].
- R4: strmSop is 1 only on a packet's first byte and strmEop only on its last. While strmValid is 1 and strmReady is 0, data and markers hold steady. strmValid is 0 in the cycle after an end byte is accepted.
- R5: On completion the engine rewrites the mode word. Bit 29 (owned by engine) is cleared, bits [10:0] take the length, and bits 31, 30 and [27:11] are kept.
- R6: A finished descriptor with next pointer 0 gets bit 28 (end of queue) set, headPtr becomes 0 and the engine goes idle. With a non-zero next pointer, bit 28 is written 0 and the next descriptor follows without software action.
- R7: A descriptor whose bit 29 is 0 is not processed. No bytes are sent, its mode word is unchanged, idle returns to 1 and headPtr keeps its value. The engine stays halted, even if the flag is later set, until headPtr is written again.
- R8: Control register (regSel=2) bit 0 enables the channel. With it 0, a loaded head does not start. Clearing it mid-chain lets the current descriptor finish and then stops, with headPtr pointing at the next descriptor. Setting it again resumes from there.
- R9: A register write with regSel=1 loads complPtr, which reads back the written value.
- R10: Writing 1 to control bit 1 raises resetBusy for RST_CYCLES cycles. During that time the stream is quiet and the engine idle, and at the end headPtr, complPtr and chanEnable are 0.
- R11: A descriptor with length 0 sends no bytes but is still written back per R5 and R6.
- R12: After end of queue, software can append a descriptor and write its address to headPtr, and the engine processes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRamWe | input | 1 | Host write strobe for descriptor RAM |
| hostRamAddr | input | IDX_W | Host RAM word index |
| hostRamWdata | input | 32 | Host RAM write data |
| hostRamRdata | output | 32 | Host RAM read data, one cycle after address |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | 0 head, 1 completion, 2 control |
| regWdata | input | 32 | Register write data |
| headPtr | output | 32 | Head pointer readback |
| complPtr | output | 32 | Completion pointer readback |
| chanEnable | output | 1 | Channel enable readback |
| resetBusy | output | 1 | Soft reset in progress |
| idle | output | 1 | Engine idle |
| strmValid | output | 1 | Stream byte valid |
| strmReady | input | 1 | Stream sink ready |
| strmData | output | 8 | Stream byte |
| strmSop | output | 1 | First byte of packet |
| strmEop | output | 1 | Last byte of packet |

## Verification
The assertions assume that software does not rewrite a descriptor or buffer word while the engine owns it. They also assume that a soft-reset request is the only thing that may withdraw a byte the sink has not yet taken. The stimulus keeps to this: every host RAM write happens while idle is 1, except for changes to descriptors that are already complete or not yet linked. Stalls come only from the sink deasserting strmReady. The stream-hold property excludes the cycle in which a soft reset is requested.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int PTR_W    = 32;
  localparam int LEN_W    = 11;
  localparam int BIT_SOP  = 31;
  localparam int BIT_EOP  = 30;
  localparam int BIT_OWN  = 29;
  localparam int BIT_EOQ  = 28;
  localparam logic [1:0] SEL_HEAD  = 2'd0;
  localparam logic [1:0] SEL_COMPL = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EVAL, ST_RDWORD, ST_WAITWORD, ST_EMIT, ST_WBACK
  } engState_t;

  typedef struct packed {
    logic       clrRegs;
    logic       descRead;
    logic [1:0] fetchIdx;
    logic       descCap;
    logic [1:0] capIdx;
    logic       startXfer;
    logic       bufRead;
    logic       bufCap;
    logic       byteTake;
    logic       writeBack;
    logic       advance;
  } dpStrobe_t;
endpackage

// File: rtl/dmaq_desc_ram.sv
module dmaq_desc_ram #(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             aWe,
  input  logic [IDX_W-1:0] aAddr,
  input  logic [31:0]      aWdata,
  output logic [31:0]      aRdata,
  input  logic             bWe,
  input  logic [IDX_W-1:0] bAddr,
  input  logic [31:0]      bWdata,
  output logic [31:0]      bRdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (aWe) mem[aAddr] <= aWdata;
    if (bWe) mem[bAddr] <= bWdata;
    aRdata <= mem[aAddr];
    bRdata <= mem[bAddr];
  end
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  localparam int RCNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rstReq,
  input  logic      headLoad,
  input  logic      chanEnable,
  input  logic      headZero,
  input  logic      ownSet,
  input  logic      lenZero,
  input  logic      nextZero,
  input  logic      lastByte,
  input  logic      laneLast,
  input  logic      strmReady,
  output dpStrobe_t stb,
  output logic      idle,
  output logic      resetBusy,
  output logic      strmValid
);
  engState_t state, nxtState;
  logic [2:0] fetchCnt;
  logic [RCNT_W-1:0] rstCnt;
  logic halted;

  assign resetBusy = (rstCnt != '0);
  assign idle      = (state == ST_IDLE);
  assign strmValid = (state == ST_EMIT);

  always_comb begin
    nxtState      = state;
    stb           = '0;
    stb.clrRegs   = resetBusy;
    stb.fetchIdx  = fetchCnt[1:0];
    stb.capIdx    = fetchCnt[1:0] - 2'd1;
    unique case (state)
      ST_IDLE: begin
        if (!resetBusy && !rstReq && chanEnable && !headZero && !halted)
          nxtState = ST_FETCH;
      end
      ST_FETCH: begin
        stb.descRead = (fetchCnt < 3'd4);
        stb.descCap  = (fetchCnt != 3'd0);
        if (fetchCnt == 3'd4) nxtState = ST_EVAL;
      end
      ST_EVAL: begin
        if (!ownSet) nxtState = ST_IDLE;
        else if (lenZero) nxtState = ST_WBACK;
        else begin
          stb.startXfer = 1'b1;
          nxtState      = ST_RDWORD;
        end
      end
      ST_RDWORD: begin
        stb.bufRead = 1'b1;
        nxtState    = ST_WAITWORD;
      end
      ST_WAITWORD: begin
        stb.bufCap = 1'b1;
        nxtState   = ST_EMIT;
      end
      ST_EMIT: begin
        if (strmReady) begin
          stb.byteTake = 1'b1;
          if (lastByte) nxtState = ST_WBACK;
          else if (laneLast) nxtState = ST_RDWORD;
        end
      end
      ST_WBACK: begin
        stb.writeBack = 1'b1;
        stb.advance   = 1'b1;
        nxtState      = (nextZero || !chanEnable) ? ST_IDLE : ST_FETCH;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fetchCnt <= '0;
      rstCnt   <= '0;
      halted   <= 1'b0;
    end else begin
      if (rstReq) rstCnt <= RCNT_W'(RST_CYCLES);
      else if (resetBusy) rstCnt <= rstCnt - 1'b1;

      if (rstReq || resetBusy) state <= ST_IDLE;
      else state <= nxtState;

      if (state == ST_FETCH && !rstReq) fetchCnt <= fetchCnt + 3'd1;
      else fetchCnt <= '0;

      if (resetBusy || headLoad) halted <= 1'b0;
      else if (state == ST_EVAL && !ownSet) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/dmaq_datapath.sv
module dmaq_datapath
  import dmaq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             idle,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [31:0]      regWdata,
  input  logic [31:0]      ramRdata,
  output logic [IDX_W-1:0] ramAddr,
  output logic             ramWe,
  output logic [31:0]      ramWdata,
  output logic [31:0]      headPtr,
  output logic [31:0]      complPtr,
  output logic             chanEnable,
  output logic             rstReq,
  output logic             headLoad,
  output logic             headZero,
  output logic             ownSet,
  output logic             lenZero,
  output logic             nextZero,
  output logic             lastByte,
  output logic             laneLast,
  output logic [7:0]       strmData,
  output logic             strmSop,
  output logic             strmEop
);
  logic [31:0]      nextPtr;
  logic [IDX_W-1:0] bufIdx;
  logic [LEN_W-1:0] lenVal;
  logic [31:0]      modeVal;
  logic [IDX_W-1:0] wordAddr;
  logic [LEN_W-1:0] remain;
  logic [1:0]       lane;
  logic [31:0]      dataWord;
  logic             firstByte;
  logic [IDX_W-1:0] headIdx;

  assign headIdx  = headPtr[IDX_W+1:2];
  assign rstReq   = regWe && (regSel == SEL_CTRL) && regWdata[1];
  assign headLoad = regWe && (regSel == SEL_HEAD) && idle && !stb.clrRegs;
  assign headZero = (headPtr == '0);
  assign ownSet   = modeVal[BIT_OWN];
  assign lenZero  = (lenVal == '0);
  assign nextZero = (nextPtr == '0);
  assign lastByte = (remain == LEN_W'(1));
  assign laneLast = (lane == 2'd3);
  assign strmData = dataWord[7:0];
  assign strmSop  = firstByte;
  assign strmEop  = lastByte;

  always_comb begin
    if (stb.descRead)       ramAddr = headIdx + IDX_W'(stb.fetchIdx);
    else if (stb.bufRead)   ramAddr = wordAddr;
    else if (stb.writeBack) ramAddr = headIdx + IDX_W'(3);
    else                    ramAddr = headIdx;
  end

  assign ramWe    = stb.writeBack;
  assign ramWdata = {modeVal[BIT_SOP], modeVal[BIT_EOP], 1'b0, nextZero,
                     modeVal[BIT_EOQ-1:LEN_W], lenVal};

  // software-visible registers
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrRegs) begin
      headPtr    <= '0;
      complPtr   <= '0;
      chanEnable <= 1'b0;
    end else begin
      if (stb.advance) headPtr <= nextPtr;
      else if (headLoad) headPtr <= regWdata;
      if (regWe && regSel == SEL_COMPL) complPtr <= regWdata;
      if (regWe && regSel == SEL_CTRL && !regWdata[1]) chanEnable <= regWdata[0];
    end
  end

  // descriptor capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPtr <= '0;
      bufIdx  <= '0;
      lenVal  <= '0;
      modeVal <= '0;
    end else if (stb.descCap) begin
      unique case (stb.capIdx)
        2'd0: nextPtr <= ramRdata;
        2'd1: bufIdx  <= ramRdata[IDX_W+1:2];
        2'd2: lenVal  <= ramRdata[LEN_W-1:0];
        default: modeVal <= ramRdata;
      endcase
    end
  end

  // byte stream state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr  <= '0;
      remain    <= '0;
      lane      <= '0;
      dataWord  <= '0;
      firstByte <= 1'b0;
    end else begin
      if (stb.startXfer) begin
        wordAddr  <= bufIdx;
        remain    <= lenVal;
        firstByte <= 1'b1;
      end else if (stb.bufCap) begin
        dataWord <= ramRdata;
        lane     <= 2'd0;
        wordAddr <= wordAddr + 1'b1;
      end else if (stb.byteTake) begin
        dataWord  <= {8'h00, dataWord[31:8]};
        lane      <= lane + 2'd1;
        remain    <= remain - 1'b1;
        firstByte <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
  import dmaq_pkg::*;
#(
  parameter int RAM_WORDS  = 256,
  parameter int RST_CYCLES = 4,
  localparam int IDX_W = $clog2(RAM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostRamWe,
  input  logic [IDX_W-1:0] hostRamAddr,
  input  logic [31:0]      hostRamWdata,
  output logic [31:0]      hostRamRdata,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [31:0]      regWdata,
  output logic [31:0]      headPtr,
  output logic [31:0]      complPtr,
  output logic             chanEnable,
  output logic             resetBusy,
  output logic             idle,
  output logic             strmValid,
  input  logic             strmReady,
  output logic [7:0]       strmData,
  output logic             strmSop,
  output logic             strmEop
);
  dpStrobe_t stb;
  logic [IDX_W-1:0] engAddr;
  logic engWe;
  logic [31:0] engWdata, engRdata;
  logic rstReq, headLoad, headZero, ownSet, lenZero, nextZero, lastByte, laneLast;

  dmaq_desc_ram #(.WORDS(RAM_WORDS)) uRam (
    .clk(clk),
    .aWe(hostRamWe), .aAddr(hostRamAddr), .aWdata(hostRamWdata), .aRdata(hostRamRdata),
    .bWe(engWe), .bAddr(engAddr), .bWdata(engWdata), .bRdata(engRdata)
  );

  dmaq_ctrl #(.RST_CYCLES(RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .rstReq(rstReq), .headLoad(headLoad),
    .chanEnable(chanEnable), .headZero(headZero), .ownSet(ownSet),
    .lenZero(lenZero), .nextZero(nextZero), .lastByte(lastByte),
    .laneLast(laneLast), .strmReady(strmReady), .stb(stb), .idle(idle),
    .resetBusy(resetBusy), .strmValid(strmValid)
  );

  dmaq_datapath #(.IDX_W(IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .idle(idle),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .ramRdata(engRdata), .ramAddr(engAddr), .ramWe(engWe), .ramWdata(engWdata),
    .headPtr(headPtr), .complPtr(complPtr), .chanEnable(chanEnable),
    .rstReq(rstReq), .headLoad(headLoad), .headZero(headZero),
    .ownSet(ownSet), .lenZero(lenZero), .nextZero(nextZero),
    .lastByte(lastByte), .laneLast(laneLast),
    .strmData(strmData), .strmSop(strmSop), .strmEop(strmEop)
  );
endmodule

// File: rtl/dmaq_engine_chk.sv
module dmaq_engine_chk
  import dmaq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regSel,
  input logic [31:0] regWdata,
  input logic [31:0] headPtr,
  input logic        chanEnable,
  input logic        resetBusy,
  input logic        idle,
  input logic        strmValid,
  input logic        strmReady,
  input logic [7:0]  strmData,
  input logic        strmSop,
  input logic        strmEop
);
  logic rstWrite;
  assign rstWrite = regWe && (regSel == SEL_CTRL) && regWdata[1];

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strmValid && !strmReady && !rstWrite |=> strmValid && $stable(strmData) && $stable(strmSop) && $stable(strmEop)); // R4
  AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    strmValid && strmReady && strmEop |=> !strmValid); // R4
  AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regSel == SEL_HEAD && idle && !resetBusy |=> headPtr == $past(regWdata)); // R2
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strmValid |-> !idle); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    resetBusy |-> !strmValid && idle); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetBusy) |-> headPtr == '0 && !chanEnable); // R10
endmodule

bind dmaq_engine dmaq_engine_chk uChk (.*);

// File: tb/dmaq_engine_test.sv
module dmaq_engine_test;
  localparam int IDX_W = 8;
  localparam int RSTC  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRamWe = 1'b0;
  logic [IDX_W-1:0] hostRamAddr = '0;
  logic [31:0] hostRamWdata = '0;
  logic [31:0] hostRamRdata;
  logic regWe = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] headPtr, complPtr;
  logic chanEnable, resetBusy, idle, strmValid, strmSop, strmEop;
  logic strmReady;
  logic [7:0] strmData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit readyHold = 1'b0;
  bit throttle = 1'b0;
  logic [7:0] gotData [512];
  bit gotSop [512];
  bit gotEop [512];
  int gotCnt = 0;

  always #4 clk = ~clk;

  dmaq_engine uut (.*);

  always @(posedge clk) strmReady <= readyHold ? 1'b0 : (throttle ? ~strmReady : 1'b1);

  always @(negedge clk) begin
    if (rstN && strmValid && strmReady && gotCnt < 512) begin
      gotData[gotCnt] = strmData;
      gotSop[gotCnt]  = strmSop;
      gotEop[gotCnt]  = strmEop;
      gotCnt++;
    end
  end

  typedef struct packed {
    logic [10:0] len;
    logic [7:0]  seed;
    logic        thr;
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{11'd1,  8'h10, 1'b0}, '{11'd4, 8'h20, 1'b0}, '{11'd7, 8'h30, 1'b1},
    '{11'd13, 8'h80, 1'b1}, '{11'd64, 8'hA0, 1'b0}};

  localparam logic [31:0] MODE_INIT = 32'hE010_0000;
  localparam logic [31:0] MODE_DONE = 32'hC010_0000;
  localparam logic [31:0] EOQ_BIT   = 32'h1000_0000;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ramWr(input int idx, input logic [31:0] d);
    @(negedge clk);
    hostRamWe = 1'b1; hostRamAddr = IDX_W'(idx); hostRamWdata = d;
    @(negedge clk);
    hostRamWe = 1'b0;
  endtask

  task automatic ramRd(input int idx, output logic [31:0] d);
    @(negedge clk);
    hostRamAddr = IDX_W'(idx);
    @(negedge clk);
    d = hostRamRdata;
  endtask

  task automatic regWr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic buildDesc(input int idx, input logic [31:0] nxt, input int bufIdx,
                           input int len, input logic [31:0] mode);
    ramWr(idx, nxt);
    ramWr(idx + 1, 32'(bufIdx * 4));
    ramWr(idx + 2, 32'(len));
    ramWr(idx + 3, mode);
  endtask

  task automatic fillBuf(input int bufIdx, input int len, input logic [7:0] seed);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++) d[b*8 +: 8] = seed + 8'(w * 4 + b);
      ramWr(bufIdx + w, d);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (!idle && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkStream(input string req, input int first, input int len, input logic [7:0] seed);
    int bad = 0;
    for (int k = 0; k < len; k++) begin
      if (gotData[first + k] !== seed + 8'(k)) bad++;
      if (gotSop[first + k] !== (k == 0)) bad++;
      if (gotEop[first + k] !== (k == len - 1)) bad++;
    end
    chkEq(req, 32'(bad), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 head", headPtr, 32'd0);
    chkEq("R1 compl", complPtr, 32'd0);
    chkEq("R1 enable/busy", {30'd0, chanEnable, resetBusy}, 32'd0);
    chkEq("R1 idle/valid", {30'd0, idle, strmValid}, 32'd2);

    regWr(2'd2, 32'd1);
    // table walk: single descriptor per vector (R3, R4, R5, R6)
    for (int v = 0; v < 5; v++) begin
      throttle = VECS[v].thr;
      buildDesc(16, 32'd0, 64, int'(VECS[v].len), MODE_INIT);
      fillBuf(64, int'(VECS[v].len), VECS[v].seed);
      base = gotCnt;
      regWr(2'd0, 32'd64);
      waitIdle();
      chkEq("R3 byte count", 32'(gotCnt - base), 32'(VECS[v].len));
      checkStream("R3 R4 bytes and markers", base, int'(VECS[v].len), VECS[v].seed);
      ramRd(19, rd);
      chkEq("R5 R6 write-back", rd, MODE_DONE | EOQ_BIT | 32'(VECS[v].len));
      chkEq("R6 head zero", headPtr, 32'd0);
    end
    throttle = 1'b0;

    // R6 two-descriptor chain
    buildDesc(16, 32'd96, 64, 5, MODE_INIT);
    buildDesc(24, 32'd0, 80, 6, MODE_INIT);
    fillBuf(64, 5, 8'h40);
    fillBuf(80, 6, 8'h50);
    base = gotCnt;
    regWr(2'd0, 32'd64);
    waitIdle();
    chkEq("R6 chain count", 32'(gotCnt - base), 32'd11);
    checkStream("R6 chain first", base, 5, 8'h40);
    checkStream("R6 chain second", base + 5, 6, 8'h50);
    ramRd(19, rd);
    chkEq("R6 first no eoq", rd, MODE_DONE | 32'd5);
    ramRd(27, rd);
    chkEq("R6 last eoq", rd, MODE_DONE | EOQ_BIT | 32'd6);

    // R12 append after drained queue and restart
    buildDesc(32, 32'd0, 96, 3, MODE_INIT);
    fillBuf(96, 3, 8'h70);
    ramWr(24, 32'd128);
    base = gotCnt;
    regWr(2'd0, 32'd128);
    waitIdle();
    chkEq("R12 restart count", 32'(gotCnt - base), 32'd3);
    checkStream("R12 restart bytes", base, 3, 8'h70);

    // R7 descriptor not owned by engine
    buildDesc(16, 32'd0, 64, 4, MODE_DONE);
    fillBuf(64, 4, 8'h11);
    base = gotCnt;
    regWr(2'd0, 32'd64);
    repeat (30) @(negedge clk);
    chkEq("R7 no bytes", 32'(gotCnt - base), 32'd0);
    chkEq("R7 idle and head kept", {idle, headPtr[30:0]}, {1'b1, 31'd64});
    ramRd(19, rd);
    chkEq("R7 mode untouched", rd, MODE_DONE);
    ramWr(19, MODE_INIT);
    repeat (20) @(negedge clk);
    chkEq("R7 stays halted", 32'(gotCnt - base), 32'd0);
    regWr(2'd0, 32'd64);
    waitIdle();
    chkEq("R7 resumes after head write", 32'(gotCnt - base), 32'd4);

    // R8 disabled channel does not start
    regWr(2'd2, 32'd0);
    buildDesc(16, 32'd0, 64, 4, MODE_INIT);
    base = gotCnt;
    regWr(2'd0, 32'd64);
    repeat (20) @(negedge clk);
    chkEq("R8 disabled no bytes", 32'(gotCnt - base), 32'd0);
    regWr(2'd2, 32'd1);
    waitIdle();
    chkEq("R8 enable starts", 32'(gotCnt - base), 32'd4);

    // R8 disable mid-chain
    buildDesc(16, 32'd96, 64, 5, MODE_INIT);
    buildDesc(24, 32'd0, 80, 6, MODE_INIT);
    fillBuf(64, 5, 8'h40);
    readyHold = 1'b1;
    base = gotCnt;
    regWr(2'd0, 32'd64);
    repeat (15) @(negedge clk);
    regWr(2'd2, 32'd0);
    readyHold = 1'b0;
    waitIdle();
    chkEq("R8 stops after current", 32'(gotCnt - base), 32'd5);
    chkEq("R8 head at next", headPtr, 32'd96);
    ramRd(27, rd);
    chkEq("R8 next untouched", rd, MODE_INIT);
    regWr(2'd2, 32'd1);
    waitIdle();
    chkEq("R8 resume count", 32'(gotCnt - base), 32'd11);
    checkStream("R8 resume bytes", base + 5, 6, 8'h50);

    // R2 head write ignored while busy
    buildDesc(16, 32'd0, 64, 5, MODE_INIT);
    readyHold = 1'b1;
    base = gotCnt;
    regWr(2'd0, 32'd64);
    repeat (12) @(negedge clk);
    regWr(2'd0, 32'h200);
    chkEq("R2 busy write ignored", headPtr, 32'd64);
    readyHold = 1'b0;
    waitIdle();
    chkEq("R2 transfer completes", 32'(gotCnt - base), 32'd5);

    // R11 zero length
    buildDesc(16, 32'd0, 64, 0, MODE_INIT);
    base = gotCnt;
    regWr(2'd0, 32'd64);
    waitIdle();
    chkEq("R11 no bytes", 32'(gotCnt - base), 32'd0);
    ramRd(19, rd);
    chkEq("R11 written back", rd, MODE_DONE | EOQ_BIT);

    // R9 completion register
    regWr(2'd1, 32'h0000_0040);
    chkEq("R9 compl readback", complPtr, 32'h40);

    // R10 soft reset
    regWr(2'd2, 32'd0);
    regWr(2'd0, 32'd64);
    chkEq("R10 head preset", headPtr, 32'd64);
    regWr(2'd2, 32'd2);
    chkEq("R10 busy raised", {31'd0, resetBusy}, 32'd1);
    repeat (RSTC) @(negedge clk);
    chkEq("R10 busy cleared", {31'd0, resetBusy}, 32'd0);
    chkEq("R10 head cleared", headPtr, 32'd0);
    chkEq("R10 compl cleared", complPtr, 32'd0);
    chkEq("R10 enable cleared", {31'd0, chanEnable}, 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule